// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO Manager

This block runs 64 independent word FIFOs whose storage all lives in one shared 32-bit data memory. Software gives each queue a configuration word that places it in the memory at a page boundary (16 words per page), sets its capacity to 16, 32, 64 or 128 words, and sets two 3-bit thresholds. After that, each queue is used through a single access address. A bus write to that address appends one word to the tail of the queue. A bus read from it removes the word at the head.

For each queue the block keeps a head offset, a fill count and its configuration. From these it derives four flags: empty, nearly-empty, nearly-full and full. The lower 32 queues also carry sticky overflow and underflow bits. The flags are packed into status words laid out differently for the two halves. The lower half gets one 4-bit nibble per queue. The upper half gets two plain bitmaps, one for nearly-empty and one for full. All registers sit on one simple request bus. Every read returns its data one cycle after the request.

Word address map (8-bit bus address): 0x00+q is the access register of queue q, 0x40+q is the configuration word of queue q, and 0x80–0x87 are the status words. Any other address reads 0, and writes to it are ignored.

Top module: `qm_fifo_mgr`

## Requirements
- R1: After reset, status words 0x80–0x83 read 0x33333333, words 0x84 and 0x85 read 0, word 0x86 reads 0xFFFFFFFF and word 0x87 reads 0. Every configuration word reads 0.
- R2: A write to 0x00+q appends the data word to queue q. A read from 0x00+q returns the oldest word still held by queue q and removes it. Read data appears on bus_rdata in the cycle after the request and holds until the next read request.
- R3: A read from an empty queue returns 0 and changes no queue. For a queue below 32, it also sets that queue's sticky underflow bit.
- R4: A write to a full queue is dropped and leaves the queue's contents and order unchanged. For a queue below 32, it also sets that queue's sticky overflow bit.
- R5: Configuration bits 25:24 give the capacity: code 0 is 16 words, 1 is 32, 2 is 64 and 3 is 128. The full flag is set exactly when the fill count equals the capacity, and the empty flag exactly when the fill count is 0.
- R6: The nearly-empty flag is set when the fill count is less than or equal to configuration bits 28:26.
- R7: The nearly-full flag is set when the free space (capacity minus fill count) is less than or equal to configuration bits 31:29.
- R8: A write to 0x40+q stores bits 31:24 and 21:14 of the data word. Bits 21:14 are the base page; the queue's storage starts at word base*16, modulo the memory size. A read of 0x40+q returns the stored bits, with all other bits reading 0. The write also empties queue q.
- R9: For queue q below 32, its flags appear in status word 0x80+q/8 at bits 4*(q%8)+3 down to 4*(q%8). Within the nibble, bit 0 is empty, bit 1 nearly-empty, bit 2 nearly-full and bit 3 full.
- R10: For queue q of 32 or above, bit q-32 of word 0x86 is its nearly-empty flag and bit q-32 of word 0x87 is its full flag.
- R11: For queue q below 32, word 0x84+q/16 holds its overflow bit at bit 2*(q%16)+1 and its underflow bit at bit 2*(q%16). Writing that word clears each sticky bit whose data bit is 1 and leaves the others unchanged.
- R12: Queues placed at different base pages do not disturb each other. A queue's head and tail wrap within its capacity, so word order is kept across many fill and drain cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after a read request |

## Verification
A wrong head offset or fill count becomes visible within a few cycles. The next pop returns a word out of order, or returns 0 where data was expected. The packed status word also stops matching the count predicted from the words pushed so far. Because the flags are decoded from the count every cycle, a wrong capacity or threshold shows up in the status read that follows the offending push or pop. A fault in the sticky bits, or in their clear mask, shows up on the next read of the sticky word after the triggering access.

// File: rtl/qm_pkg.sv
package qm_pkg;

  localparam int REG_W      = 32;
  localparam int PAGE_SHIFT = 4;
  localparam int PAGE_WORDS = 1 << PAGE_SHIFT;
  localparam int BASE_W     = 8;
  localparam int WM_W       = 3;
  localparam int LEN_W      = 2;
  localparam int PTR_W      = 7;
  localparam int FILL_W     = 8;

  // Configuration word field positions (software-visible layout)
  localparam int BASE_LSB = 14;
  localparam int LEN_LSB  = 24;
  localparam int NE_LSB   = 26;
  localparam int NF_LSB   = 29;

  // Flag nibble bit order
  localparam int FLG_EMPTY = 0;
  localparam int FLG_NE    = 1;
  localparam int FLG_NF    = 2;
  localparam int FLG_FULL  = 3;

  typedef struct packed {
    logic [WM_W-1:0]   nf_wm;
    logic [WM_W-1:0]   ne_wm;
    logic [LEN_W-1:0]  len_code;
    logic [BASE_W-1:0] base_pg;
  } qm_cfg_t;

  typedef enum logic [1:0] {
    RG_ACCESS = 2'd0,
    RG_CONFIG = 2'd1,
    RG_STATUS = 2'd2,
    RG_SPARE  = 2'd3
  } qm_region_e;

  typedef enum logic {
    RD_FROM_REG = 1'b0,
    RD_FROM_RAM = 1'b1
  } qm_rdsrc_e;

  function automatic logic [FILL_W-1:0] cap_words(logic [LEN_W-1:0] code);
    return FILL_W'(PAGE_WORDS) << code;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(qm_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[BASE_LSB +: BASE_W] = c.base_pg;
    w[LEN_LSB  +: LEN_W]  = c.len_code;
    w[NE_LSB   +: WM_W]   = c.ne_wm;
    w[NF_LSB   +: WM_W]   = c.nf_wm;
    return w;
  endfunction

endpackage

// File: rtl/qm_rst_sync.sv
module qm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/qm_word_ram.sv
module qm_word_ram #(
  parameter int WORDS = 2048,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/qm_queue_ctx.sv
module qm_queue_ctx
  import qm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  qm_cfg_t          cfg_in,
  input  logic             push,
  input  logic             pop,
  output qm_cfg_t          cfg_q,
  output logic [PTR_W-1:0] rd_off,
  output logic [PTR_W-1:0] wr_off,
  output logic [3:0]       flags
);

  qm_cfg_t           cfg_r, cfg_n;
  logic [PTR_W-1:0]  rd_r, rd_n;
  logic [FILL_W-1:0] fill_r, fill_n;
  logic [FILL_W-1:0] cap;
  logic [FILL_W-1:0] room;
  logic [PTR_W-1:0]  wrap_mask;
  logic              upd_en;

  assign cap       = cap_words(cfg_r.len_code);
  assign room      = cap - fill_r;
  assign wrap_mask = PTR_W'(cap - FILL_W'(1));
  assign upd_en    = cfg_we | push | pop;

  always_comb begin
    cfg_n  = cfg_r;
    rd_n   = rd_r;
    fill_n = fill_r;
    if (cfg_we) begin
      cfg_n  = cfg_in;
      rd_n   = '0;
      fill_n = '0;
    end else if (push) begin
      fill_n = fill_r + FILL_W'(1);
    end else if (pop) begin
      rd_n   = (rd_r + PTR_W'(1)) & wrap_mask;
      fill_n = fill_r - FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r  <= '0;
      rd_r   <= '0;
      fill_r <= '0;
    end else if (upd_en) begin
      cfg_r  <= cfg_n;
      rd_r   <= rd_n;
      fill_r <= fill_n;
    end
  end

  assign cfg_q  = cfg_r;
  assign rd_off = rd_r;
  assign wr_off = (rd_r + PTR_W'(fill_r)) & wrap_mask;

  assign flags[FLG_EMPTY] = (fill_r == '0);
  assign flags[FLG_NE]    = (fill_r <= FILL_W'(cfg_r.ne_wm));
  assign flags[FLG_NF]    = (room <= FILL_W'(cfg_r.nf_wm));
  assign flags[FLG_FULL]  = (fill_r == cap);

endmodule

// File: rtl/qm_status_pack.sv
module qm_status_pack
  import qm_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int SEL_W = 6,
  localparam int LO_WORDS = HALF / 8,
  localparam int ST_WORDS = HALF / 16
) (
  input  logic [HALF-1:0][3:0] lo_nib,
  input  logic [HALF-1:0]      hi_ne,
  input  logic [HALF-1:0]      hi_full,
  input  logic [HALF-1:0]      ovf,
  input  logic [HALF-1:0]      udf,
  input  logic [SEL_W-1:0]     sel,
  output logic [REG_W-1:0]     word
);

  logic [REG_W-1:0] lo_w [LO_WORDS];
  logic [REG_W-1:0] st_w [ST_WORDS];
  logic [REG_W-1:0] ne_map, full_map;

  for (genvar w = 0; w < LO_WORDS; w++) begin : g_lo
    for (genvar j = 0; j < 8; j++) begin : g_nib
      assign lo_w[w][4*j +: 4] = lo_nib[8*w + j];
    end
  end

  for (genvar w = 0; w < ST_WORDS; w++) begin : g_st
    for (genvar j = 0; j < 16; j++) begin : g_fld
      assign st_w[w][2*j+1] = ovf[16*w + j];
      assign st_w[w][2*j]   = udf[16*w + j];
    end
  end

  assign ne_map   = REG_W'(hi_ne);
  assign full_map = REG_W'(hi_full);

  always_comb begin
    word = '0;
    for (int w = 0; w < LO_WORDS; w++) begin
      if (int'(sel) == w) word = lo_w[w];
    end
    for (int w = 0; w < ST_WORDS; w++) begin
      if (int'(sel) == LO_WORDS + w) word = st_w[w];
    end
    if (int'(sel) == LO_WORDS + ST_WORDS)     word = ne_map;
    if (int'(sel) == LO_WORDS + ST_WORDS + 1) word = full_map;
  end

endmodule

// File: rtl/qm_fifo_mgr.sv
module qm_fifo_mgr
  import qm_pkg::*;
#(
  parameter int NUM_Q     = 64,
  parameter int RAM_WORDS = 2048,
  localparam int QW       = $clog2(NUM_Q),
  localparam int ADDR_W   = QW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);

  localparam int HALF     = NUM_Q / 2;
  localparam int LO_WORDS = HALF / 8;
  localparam int RAM_AW   = $clog2(RAM_WORDS);
  localparam int PHYS_W   = BASE_W + PAGE_SHIFT;

  logic rst_n_sync;

  qm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Decode
  qm_region_e region;
  logic [QW-1:0] qi;
  logic acc_wr, acc_rd, cfg_wr, stat_wr, rd_req, is_lower;

  assign region   = qm_region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign qi       = bus_addr[QW-1:0];
  assign is_lower = ~qi[QW-1];
  assign rd_req   = bus_req & ~bus_we;
  assign acc_wr   = bus_req &  bus_we & (region == RG_ACCESS);
  assign acc_rd   = rd_req & (region == RG_ACCESS);
  assign cfg_wr   = bus_req &  bus_we & (region == RG_CONFIG);
  assign stat_wr  = bus_req &  bus_we & (region == RG_STATUS);

  qm_cfg_t cfg_in;
  always_comb begin
    cfg_in.base_pg  = bus_wdata[BASE_LSB +: BASE_W];
    cfg_in.len_code = bus_wdata[LEN_LSB  +: LEN_W];
    cfg_in.ne_wm    = bus_wdata[NE_LSB   +: WM_W];
    cfg_in.nf_wm    = bus_wdata[NF_LSB   +: WM_W];
  end

  // Per-queue contexts
  qm_cfg_t [NUM_Q-1:0]          cfg_arr;
  logic    [NUM_Q-1:0][PTR_W-1:0] rd_arr, wr_arr;
  logic    [NUM_Q-1:0][3:0]     flag_nib;
  logic sel_empty, sel_full, push_ok, pop_ok;

  assign sel_empty = flag_nib[qi][FLG_EMPTY];
  assign sel_full  = flag_nib[qi][FLG_FULL];
  assign push_ok   = acc_wr & ~sel_full;
  assign pop_ok    = acc_rd & ~sel_empty;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hit;
    assign hit = (qi == QW'(q));
    qm_queue_ctx u_ctx (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .cfg_we (cfg_wr & hit),
      .cfg_in (cfg_in),
      .push   (push_ok & hit),
      .pop    (pop_ok & hit),
      .cfg_q  (cfg_arr[q]),
      .rd_off (rd_arr[q]),
      .wr_off (wr_arr[q]),
      .flags  (flag_nib[q])
    );
  end

  // Shared storage
  qm_cfg_t sel_cfg;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [REG_W-1:0]  ram_rdata;

  assign sel_cfg   = cfg_arr[qi];
  assign ram_waddr = RAM_AW'({sel_cfg.base_pg, {PAGE_SHIFT{1'b0}}} + PHYS_W'(wr_arr[qi]));
  assign ram_raddr = RAM_AW'({sel_cfg.base_pg, {PAGE_SHIFT{1'b0}}} + PHYS_W'(rd_arr[qi]));

  qm_word_ram #(
    .WORDS (RAM_WORDS),
    .DW    (REG_W)
  ) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (ram_waddr),
    .wdata (bus_wdata),
    .re    (pop_ok),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // Sticky overflow / underflow for the lower half
  logic [HALF-1:0] ovf_q, ovf_n, udf_q, udf_n;
  logic ovf_set, udf_set, stk_en;

  assign ovf_set = acc_wr & sel_full  & is_lower;
  assign udf_set = acc_rd & sel_empty & is_lower;
  assign stk_en  = stat_wr | ovf_set | udf_set;

  always_comb begin
    ovf_n = ovf_q;
    udf_n = udf_q;
    for (int j = 0; j < HALF; j++) begin
      if (stat_wr && (int'(qi) == LO_WORDS + j / 16)) begin
        if (bus_wdata[2*(j%16)+1]) ovf_n[j] = 1'b0;
        if (bus_wdata[2*(j%16)])   udf_n[j] = 1'b0;
      end
      if (ovf_set && (int'(qi) == j)) ovf_n[j] = 1'b1;
      if (udf_set && (int'(qi) == j)) udf_n[j] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ovf_q <= '0;
      udf_q <= '0;
    end else if (stk_en) begin
      ovf_q <= ovf_n;
      udf_q <= udf_n;
    end
  end

  // Status packing
  logic [HALF-1:0][3:0] lo_nib;
  logic [HALF-1:0]      hi_ne, hi_full;
  logic [REG_W-1:0]     stat_word;

  for (genvar j = 0; j < HALF; j++) begin : g_half
    assign lo_nib[j]  = flag_nib[j];
    assign hi_ne[j]   = flag_nib[HALF + j][FLG_NE];
    assign hi_full[j] = flag_nib[HALF + j][FLG_FULL];
  end

  qm_status_pack #(
    .HALF  (HALF),
    .SEL_W (QW)
  ) u_pack (
    .lo_nib  (lo_nib),
    .hi_ne   (hi_ne),
    .hi_full (hi_full),
    .ovf     (ovf_q),
    .udf     (udf_q),
    .sel     (qi),
    .word    (stat_word)
  );

  // Read return path
  qm_rdsrc_e        rsrc_q, rsrc_n;
  logic [REG_W-1:0] rreg_q, rreg_n;

  always_comb begin
    rsrc_n = RD_FROM_REG;
    rreg_n = '0;
    unique case (region)
      RG_ACCESS: if (!sel_empty) rsrc_n = RD_FROM_RAM;
      RG_CONFIG: rreg_n = cfg_pack(sel_cfg);
      RG_STATUS: rreg_n = stat_word;
      default:   rreg_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsrc_q <= RD_FROM_REG;
      rreg_q <= '0;
    end else if (rd_req) begin
      rsrc_q <= rsrc_n;
      rreg_q <= rreg_n;
    end
  end

  assign bus_rdata = (rsrc_q == RD_FROM_RAM) ? ram_rdata : rreg_q;

endmodule

// File: rtl/qm_fifo_mgr_chk.sv
module qm_fifo_mgr_chk
  import qm_pkg::*;
#(
  parameter int NUM_Q  = 64,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_req,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [REG_W-1:0]      bus_rdata,
  input logic [NUM_Q-1:0][3:0] flag_nib
);

  localparam int QW = $clog2(NUM_Q);

  logic [QW-1:0] qi;
  logic acc_rd, cfg_wr, rd_req;

  assign qi     = bus_addr[QW-1:0];
  assign rd_req = bus_req & ~bus_we;
  assign acc_rd = rd_req  & (bus_addr[ADDR_W-1 -: 2] == 2'd0);
  assign cfg_wr = bus_req & bus_we & (bus_addr[ADDR_W-1 -: 2] == 2'd1);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_nib[q][FLG_EMPTY] && flag_nib[q][FLG_FULL])); // R5
    AST_EMPTY_NEARLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_nib[q][FLG_EMPTY] |-> flag_nib[q][FLG_NE]); // R6
    AST_FULL_NEARLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      flag_nib[q][FLG_FULL] |-> flag_nib[q][FLG_NF]); // R7
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && flag_nib[qi][FLG_EMPTY]) |=> (bus_rdata == '0)); // R3

  AST_CFG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> flag_nib[$past(qi)][FLG_EMPTY]); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata)); // R2

endmodule

bind qm_fifo_mgr qm_fifo_mgr_chk #(
  .NUM_Q  (NUM_Q),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .flag_nib  (flag_nib)
);

// File: tb/tb_qm_fifo_mgr.sv
module tb_qm_fifo_mgr;

  logic        clk;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks;
  int failures;
  bit done;

  qm_fifo_mgr dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model
  logic [31:0] m_data [64][$];
  int m_code [64];
  int m_ne   [64];
  int m_nf   [64];
  bit m_ovf  [64];
  bit m_udf  [64];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [3:0] exp_nib(int q);
    int cap;
    int f;
    cap = 16 << m_code[q];
    f   = m_data[q].size();
    return {(f == cap), ((cap - f) <= m_nf[q]), (f <= m_ne[q]), (f == 0)};
  endfunction

  function automatic logic [31:0] exp_lo_word(int w);
    logic [31:0] r;
    for (int j = 0; j < 8; j++) r[4*j +: 4] = exp_nib(8*w + j);
    return r;
  endfunction

  function automatic logic [31:0] exp_stk_word(int w);
    logic [31:0] r;
    for (int j = 0; j < 16; j++) begin
      r[2*j+1] = m_ovf[16*w + j];
      r[2*j]   = m_udf[16*w + j];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_hi_map(int bitsel);
    logic [31:0] r;
    logic [3:0]  n;
    for (int j = 0; j < 32; j++) begin
      n    = exp_nib(32 + j);
      r[j] = n[bitsel];
    end
    return r;
  endfunction

  task automatic check_flags(int q, string tag);
    logic [31:0] d;
    if (q < 32) begin
      bus_rd(8'(8'h80 + q / 8), d);
      check(tag, d, exp_lo_word(q / 8));            // R9 whole-word packing
    end else begin
      bus_rd(8'h86, d);
      check({tag, " R10 ne-map"}, d, exp_hi_map(1));
      bus_rd(8'h87, d);
      check({tag, " R10 full-map"}, d, exp_hi_map(3));
    end
  endtask

  task automatic check_sticky(int q, string tag);
    logic [31:0] d;
    bus_rd(8'(8'h84 + q / 16), d);
    check(tag, d, exp_stk_word(q / 16));
  endtask

  task automatic cfg_q(int q, int code, int base, int ne, int nf, logic [31:0] junk);
    logic [31:0] w;
    w = (32'(nf) << 29) | (32'(ne) << 26) | (32'(code) << 24) | (32'(base) << 14) | junk;
    bus_wr(8'(8'h40 + q), w);
    m_code[q] = code; m_ne[q] = ne; m_nf[q] = nf;
    m_data[q].delete();
  endtask

  task automatic push_q(int q, logic [31:0] v);
    bus_wr(8'(q), v);
    if (m_data[q].size() == (16 << m_code[q])) begin
      if (q < 32) m_ovf[q] = 1'b1;
    end else begin
      m_data[q].push_back(v);
    end
  endtask

  task automatic pop_q(int q, string tag);
    logic [31:0] d, e;
    bus_rd(8'(q), d);
    if (m_data[q].size() == 0) begin
      e = '0;
      if (q < 32) m_udf[q] = 1'b1;
    end else begin
      e = m_data[q].pop_front();
    end
    check(tag, d, e);
  endtask

  function automatic logic [31:0] pat(int q, int i);
    return {8'(q), 8'hA5, 16'(i * 7 + 3)};
  endfunction

  initial begin
    logic [31:0] d;
    int sq [4];
    int sb [4];
    int sne[4];
    int snf[4];
    checks = 0; failures = 0; done = 1'b0;
    for (int q = 0; q < 64; q++) begin
      m_code[q] = 0; m_ne[q] = 0; m_nf[q] = 0; m_ovf[q] = 0; m_udf[q] = 0;
    end
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values of every status word and a configuration word
    for (int k = 0; k < 4; k++) begin
      bus_rd(8'(8'h80 + k), d);
      check("R1 lower status reset", d, 32'h33333333);
    end
    bus_rd(8'h84, d); check("R1 sticky word0 reset", d, 32'h0);
    bus_rd(8'h85, d); check("R1 sticky word1 reset", d, 32'h0);
    bus_rd(8'h86, d); check("R1 upper ne-map reset", d, 32'hFFFFFFFF);
    bus_rd(8'h87, d); check("R1 upper full-map reset", d, 32'h0);
    bus_rd(8'h45, d); check("R1 config reset", d, 32'h0);

    // R3: read from an empty queue gives 0 and sets underflow
    pop_q(0, "R3 empty read data");
    check_sticky(0, "R3 underflow sticky");

    // R8: configuration readback drops the unused bits
    cfg_q(3, 0, 4, 2, 3, 32'h00C03FFF);
    bus_rd(8'h43, d);
    check("R8 config readback", d, ((32'd3 << 29) | (32'd2 << 26) | (32'd4 << 14)));

    // R5 R6 R7 R4 R2 R3: sweep of all four capacities, lower and upper queues
    sq  = '{3, 17, 40, 63};
    sb  = '{4, 6, 10, 16};
    sne = '{2, 5, 7, 0};
    snf = '{3, 1, 6, 7};
    for (int s = 0; s < 4; s++) begin
      int q;
      int cap;
      q   = sq[s];
      cap = 16 << s;
      cfg_q(q, s, sb[s], sne[s], snf[s], 32'h0);
      check_flags(q, "R5 empty after config");
      for (int i = 0; i <= cap; i++) begin
        push_q(q, pat(q, i));
        check_flags(q, "R5 R6 R7 flags while filling");
      end
      if (q < 32) check_sticky(q, "R4 overflow sticky");
      for (int i = 0; i <= cap; i++) begin
        pop_q(q, "R2 R4 FIFO order and dropped word");
        check_flags(q, "R6 R7 flags while draining");
      end
      if (q < 32) check_sticky(q, "R3 underflow after drain");
    end

    // R11: write-one-to-clear of individual sticky bits
    bus_wr(8'h84, 32'h1 << 7);
    m_ovf[3] = 1'b0;
    check_sticky(3, "R11 clear overflow only");
    bus_wr(8'h84, 32'h0);
    check_sticky(3, "R11 zero write keeps bits");
    bus_wr(8'h84, 32'h1 << 6);
    m_udf[3] = 1'b0;
    check_sticky(3, "R11 clear underflow");
    bus_wr(8'h85, 32'hFFFFFFFF);
    m_ovf[17] = 1'b0; m_udf[17] = 1'b0;
    check_sticky(17, "R11 clear whole word");

    // R12: neighbouring queues and pointer wrap
    cfg_q(3, 0, 4, 1, 1, 32'h0);
    cfg_q(4, 0, 5, 1, 1, 32'h0);
    for (int i = 0; i < 10; i++) push_q(3, pat(3, 100 + i));
    for (int i = 0; i < 10; i++) pop_q(3, "R12 first pass");
    for (int i = 0; i < 12; i++) begin
      push_q(3, pat(3, 200 + i));
      if (i < 5) push_q(4, pat(4, 300 + i));
    end
    check_flags(3, "R12 status after interleave");
    for (int i = 0; i < 5; i++) pop_q(4, "R12 neighbour data");
    for (int i = 0; i < 12; i++) pop_q(3, "R12 wrapped data");
    check_flags(17, "R12 unrelated queue untouched");

    // R8: reconfiguring a filled queue empties it
    for (int i = 0; i < 3; i++) push_q(4, pat(4, 400 + i));
    check_flags(4, "R9 partially filled");
    cfg_q(4, 1, 5, 0, 0, 32'h0);
    check_flags(4, "R8 reconfig empties");
    pop_q(4, "R8 reconfig drops data");

    // R10: upper-half bitmap position for another queue
    cfg_q(50, 0, 30, 1, 0, 32'h0);
    for (int i = 0; i < 16; i++) push_q(50, pat(50, i));
    check_flags(50, "R10 upper full");
    pop_q(50, "R2 upper queue head");
    check_flags(50, "R10 upper after pop");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule